// File: doc/BRIEF.md
# Digit-Serial Ternary Field Multiplier

This block multiplies two elements of the characteristic-three extension field GF(3^M), reducing modulo the trinomial f(x) = x^M + x^K + 2 (defaults M = 97, K = 12). Each operand is a polynomial of M ternary coefficients. The multiplier walks operand `a` one digit of D coefficients per clock, highest-order digit first, forming a D-by-M partial product against `b` and merging it into a wide accumulator by Horner's rule: the accumulator is reduced, shifted up by D positions and summed with the new partial product.

No dedicated output reducer exists. After the last real digit, one further Horner step runs with an all-zero digit. This leaves x^D times the reduced product in the accumulator, and the answer is simply its top M coefficients. A multiplication therefore takes ceil(M/D)+1 clocks after the start strobe: 34 clocks for the defaults with D = 3.

A host pulses `start` with both operands on the input buses. The operands are captured on that edge, `a` into a zero-padded shift register and `b` into a plain holding register. `done` rises when the product is ready on `result`.

Top module: `mse_gf3_mult`

## Requirements
- R1: Every field element is packed two bits per coefficient, coefficient i in bits [2i+1:2i], with code 00 = 0, 01 = 1, 10 = 2; code 11 is never driven on `result`.
- R2: After a multiplication `result` equals a(x)·b(x) mod (x^M + x^K + 2), for arbitrary operands including all-2 operands.
- R3: `done` rises exactly ceil(M/D)+1 clock edges after the edge that samples `start` (34 for the defaults).
- R4: While `start` stays low, `done` stays high and `result` does not change once a product is ready.
- R5: A `start` pulse during a running multiplication abandons it, clears `done` on the next edge, and only the new operands' product is reported.
- R6: While `rst` is high and on the first edge after it, `done` is 0 and `result` is all zero.
- R7: A zero operand gives a zero product, and an operand equal to the constant 1 returns the other operand unchanged.
- R8: Products that reach degree M or more are folded using x^M ≡ 2x^K + 1; in particular x^(M-1)·x yields 2x^K + 1.
- R9: The digit fed to the final Horner step is all zero, because the shift register is zero-padded at the top and fills with zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; operands sampled on this edge |
| a_in | input | 2*M | Operand a, shifted in digit by digit |
| b_in | input | 2*M | Operand b, held for the whole multiplication |
| done | output | 1 | Product on `result` is valid |
| result | output | 2*M | Registered product a·b mod f |

## Verification
On every cycle the assertions check the start-to-done latency against an independent cycle counter, the stability of a finished result, the clearing of `done` by a new start, the reset values, the zero digit entering the final step and the absence of the unused code 11 in the accumulator. Whether the arithmetic is right can only be shown by the bench. It runs random, all-2, zero, one and overflow-boundary operand pairs, plus an interrupted multiplication, and compares each product against a schoolbook multiply-then-reduce reference.

// File: rtl/mse_gf3_pkg.sv
package mse_gf3_pkg;
  typedef logic [1:0] trit_t;

  // sum of two ternary digits, 00/01/10 coding
  function automatic trit_t t_add(input trit_t x, input trit_t y);
    logic [2:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  // negation swaps the two bits of the code
  function automatic trit_t t_neg(input trit_t x);
    return {x[0], x[1]};
  endfunction

  function automatic trit_t t_mul(input trit_t x, input trit_t y);
    if (x == 2'b01) return y;
    if (x == 2'b10) return t_neg(y);
    return 2'b00;
  endfunction

  function automatic logic any_bad(input logic [1023:0] v, input int n);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < n; i++) if (v[2*i +: 2] == 2'b11) bad = 1'b1;
    return bad;
  endfunction
endpackage

// File: rtl/mse_gf3_dsrc.sv
module mse_gf3_dsrc #(
  parameter int M = 97,
  parameter int D = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           shift,
  input  logic           last,
  input  logic [2*M-1:0] a_in,
  output logic [2*D-1:0] dig
);
  localparam int NDIG = (M + D - 1) / D;
  localparam int AW   = 2 * NDIG * D;

  logic [AW-1:0] a_sr;

  always_ff @(posedge clk) begin
    if (rst)        a_sr <= '0;
    else if (load)  a_sr <= AW'(a_in);
    else if (shift) a_sr <= a_sr << (2 * D);
  end

  // trit j of the digit is coefficient D*i + j of a
  assign dig = a_sr[AW-1 -: 2*D];

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (rst)
    last |-> dig == '0);
endmodule

// File: rtl/mse_gf3_ppg.sv
module mse_gf3_ppg
  import mse_gf3_pkg::*;
#(
  parameter int M = 97,
  parameter int D = 3
) (
  input  logic [2*D-1:0]       dig,
  input  logic [2*M-1:0]       b,
  output logic [2*(M+D-1)-1:0] t
);
  localparam int TN = M + D - 1;

  for (genvar n = 0; n < TN; n++) begin : g_coef
    always_comb begin
      trit_t acc;
      acc = 2'b00;
      for (int j = 0; j < D; j++) begin
        if (n - j >= 0 && n - j < M)
          acc = t_add(acc, t_mul(dig[2*j +: 2], b[2*(n-j) +: 2]));
      end
      t[2*n +: 2] = acc;
    end
  end
endmodule

// File: rtl/mse_gf3_acc.sv
module mse_gf3_acc
  import mse_gf3_pkg::*;
#(
  parameter int M = 97,
  parameter int K = 12,
  parameter int D = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic [2*(M+D-1)-1:0] t,
  output logic [2*(M+D)-1:0]   s_nxt
);
  localparam int SN = M + D;

  logic [2*SN-1:0] s_q;
  logic [2*M-1:0]  r;

  // fold coefficients M..M+D-1 with x^(M+j) = 2x^(K+j) + x^j
  for (genvar n = 0; n < M; n++) begin : g_red
    always_comb begin
      trit_t v;
      v = s_q[2*n +: 2];
      for (int j = 0; j < D; j++) begin
        if (n == j)     v = t_add(v, s_q[2*(M+j) +: 2]);
        if (n == K + j) v = t_add(v, t_neg(s_q[2*(M+j) +: 2]));
      end
      r[2*n +: 2] = v;
    end
  end

  // s_next = t + x^D * (s mod f)
  for (genvar n = 0; n < SN; n++) begin : g_nxt
    always_comb begin
      trit_t v;
      v = 2'b00;
      if (n <= M + D - 2) v = t[2*n +: 2];
      if (n >= D)         v = t_add(v, r[2*(n-D) +: 2]);
      s_nxt[2*n +: 2] = v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) s_q <= '0;
    else if (en)    s_q <= s_nxt;
  end

  p_acc_codes_r1: assert property (@(posedge clk) disable iff (rst)
    !any_bad(1024'(s_q), SN));
endmodule

// File: rtl/mse_gf3_mult.sv
module mse_gf3_mult #(
  parameter int M = 97,
  parameter int K = 12,
  parameter int D = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*M-1:0] a_in,
  input  logic [2*M-1:0] b_in,
  output logic           done,
  output logic [2*M-1:0] result
);
  localparam int NDIG  = (M + D - 1) / D;
  localparam int STEPS = NDIG + 1;
  localparam int CW    = $clog2(STEPS + 1);

  logic                 busy;
  logic [CW-1:0]        cnt;
  logic [2*M-1:0]       b_q;
  logic [2*D-1:0]       dig;
  logic [2*(M+D-1)-1:0] t;
  logic [2*(M+D)-1:0]   s_nxt;
  logic                 last;

  assign last = busy && (cnt == CW'(NDIG));

  mse_gf3_dsrc #(.M(M), .D(D)) u_dsrc (
    .clk(clk), .rst(rst), .load(start), .shift(busy && !start),
    .last(last && !start), .a_in(a_in), .dig(dig)
  );

  mse_gf3_ppg #(.M(M), .D(D)) u_ppg (.dig(dig), .b(b_q), .t(t));

  mse_gf3_acc #(.M(M), .K(K), .D(D)) u_acc (
    .clk(clk), .rst(rst), .clr(start), .en(busy), .t(t), .s_nxt(s_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      result <= '0;
      b_q    <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      done <= 1'b0;
      b_q  <= b_in;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= s_nxt[2*(M+D)-1 : 2*D];
      end
    end
  end

  // independent cycle count since the last start
  logic [CW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)                      lat_q <= CW'(STEPS);
    else if (start)               lat_q <= '0;
    else if (lat_q < CW'(STEPS))  lat_q <= lat_q + 1'b1;
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> lat_q == CW'(STEPS));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result)));
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);
  p_reset_state_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && result == '0));
endmodule

// File: tb/mse_gf3_mult_tb.sv
module mse_gf3_mult_tb;
  localparam int M = 97;
  localparam int K = 12;
  localparam int D = 3;
  localparam int STEPS = (M + D - 1) / D + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2*M-1:0] a_in = '0, b_in = '0;
  logic done;
  logic [2*M-1:0] result;

  int total = 0, bad = 0, poscnt = 0, start_cnt = 0;
  bit finished = 0, done_prev = 0;
  logic [2*M-1:0] exp_q[$];
  string tag_q[$];

  mse_gf3_mult #(.M(M), .K(K), .D(D)) u_dut (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .done(done), .result(result)
  );

  always #10 clk = ~clk;
  always @(posedge clk) poscnt++;

  function automatic logic [2*M-1:0] mono(input int e, input int c);
    logic [2*M-1:0] v;
    v = '0;
    v[2*e +: 2] = (c == 1) ? 2'b01 : 2'b10;
    return v;
  endfunction

  function automatic logic [2*M-1:0] rnd_el();
    logic [2*M-1:0] v;
    for (int i = 0; i < M; i++) v[2*i +: 2] = 2'(($urandom % 3));
    return v;
  endfunction

  // schoolbook product then reduction with x^M = 2x^K + 1
  function automatic logic [2*M-1:0] ref_mul(input logic [2*M-1:0] a, input logic [2*M-1:0] b);
    int p [0:2*M-2];
    int c;
    logic [2*M-1:0] v;
    for (int i = 0; i < 2*M-1; i++) p[i] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        p[i+j] = (p[i+j] + int'(a[2*i +: 2]) * int'(b[2*j +: 2])) % 3;
    for (int n = 2*M-2; n >= M; n--) begin
      c = p[n];
      p[n] = 0;
      p[n-M+K] = (p[n-M+K] + 2*c) % 3;
      p[n-M]   = (p[n-M] + c) % 3;
    end
    for (int i = 0; i < M; i++) v[2*i +: 2] = 2'(p[i]);
    return v;
  endfunction

  function automatic bit has_bad(input logic [2*M-1:0] v);
    for (int i = 0; i < M; i++) if (v[2*i +: 2] == 2'b11) return 1;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  task automatic run_mul(input logic [2*M-1:0] a, input logic [2*M-1:0] b, input string tag);
    exp_q.push_back(ref_mul(a, b));
    tag_q.push_back(tag);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1; start_cnt = poscnt;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: pop and compare on each rising done
  always @(negedge clk) begin
    if (!rst && done && !done_prev) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected result", $sformatf("%h", result), "none");
      end else begin
        logic [2*M-1:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(result == e, tg, $sformatf("%h", result), $sformatf("%h", e));
        check(!has_bad(result), "R1 code 11", $sformatf("%h", result), "no 11");
        check(poscnt - start_cnt - 1 == STEPS, "R3 latency",
              $sformatf("%0d", poscnt - start_cnt - 1), $sformatf("%0d", STEPS));
      end
    end
    done_prev = done;
  end

  initial begin
    logic [2*M-1:0] x, y, one, hold;
    one = mono(0, 1);
    repeat (3) @(negedge clk);
    check(done == 1'b0 && result == '0, "R6 in reset", $sformatf("%b/%h", done, result), "0/0");
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && result == '0, "R6 after reset", $sformatf("%b/%h", done, result), "0/0");

    x = rnd_el();
    run_mul('0, x, "R7 zero times x");
    run_mul(x, '0, "R7 x times zero");
    run_mul(one, x, "R7 one times x");
    run_mul(x, one, "R7 x times one");
    check(result == x, "R7 identity direct", $sformatf("%h", result), $sformatf("%h", x));

    run_mul(mono(M-1, 1), mono(1, 1), "R8 x^96*x");
    check(result == (mono(K, 2) | mono(0, 1)), "R8 fold value",
          $sformatf("%h", result), "2x^K+1");
    run_mul(mono(M-1, 2), mono(M-1, 1), "R8 top times top");
    run_mul(mono(M-2, 1), mono(3, 2), "R9 wrap through digits");

    for (int i = 0; i < M; i++) begin x[2*i +: 2] = 2'b10; y[2*i +: 2] = 2'b10; end
    run_mul(x, y, "R2 all twos");

    for (int k = 0; k < 20; k++) run_mul(rnd_el(), rnd_el(), "R2 random");

    hold = result;
    repeat (12) @(negedge clk);
    check(done == 1'b1 && result == hold, "R4 hold",
          $sformatf("%b/%h", done, result), $sformatf("1/%h", hold));

    // abandon a running product; only the second is reported
    @(negedge clk);
    a_in = rnd_el(); b_in = rnd_el(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R5 done cleared", $sformatf("%b", done), "0");
    repeat (5) @(negedge clk);
    run_mul(rnd_el(), rnd_el(), "R5 restart product");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule